// File: doc/BRIEF.md
# Fuse-Backed Dual Wiper Code Controller

This block keeps the two 8-bit position codes that set the taps of a pair of digital resistor dividers, and gives each channel a one-time store that fixes its start-up code. An upstream serial-bus decoder hands it one parsed command at a time on a valid/ready pair: write a code to a channel, read a channel's live code back, or burn a channel's present code into its store. The two codes leave the block as a flat bus that goes straight to the resistor array.

A channel whose store was never burned starts at midscale after every reset. Burning copies the channel's present code into sticky storage that is modelled as write-once flip-flops. The burn then keeps the block busy for a long, parameterised window, standing in for the few hundred milliseconds the physical programming takes. While the block is busy, `cmd_ready` is low and no command is taken. After a burn, writes still move the wiper, but only until the next reset. From then on every reset brings the channel back to its burned code instead of midscale. A second burn of a channel that is already burned, and the unused opcode, each raise a one-cycle error pulse and change nothing.

Top module: `wiper_otp_ctrl`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a rising edge), each channel whose store is unburned shows code 0x80, `fused` is all zero, and `busy`, `err` and `rsp_valid` are 0.
- R2: A write (`cmd_op` = 2'b00) taken while `cmd_ready` is high puts `cmd_data` on the selected channel's code on the next cycle and leaves the other channel unchanged. Channel c occupies bits [8c+7:8c] of `wipers`, and every code from 0x00 to 0xFF is kept.
- R3: A read (`cmd_op` = 2'b01) that is taken raises `rsp_valid` for exactly one cycle on the next cycle, with `rsp_data` equal to the selected channel's live code.
- R4: A burn (`cmd_op` = 2'b10) taken on an unburned channel sets that channel's `fused` bit on the next cycle and captures its present code. `busy` is then high, and `cmd_ready` low, for exactly PROG_CYCLES cycles, starting with the next cycle.
- R5: While `busy` is high, no command is taken: a held `cmd_valid` changes no code, store, response or error until `busy` falls.
- R6: A burn taken on a channel whose `fused` bit is set raises `err` for one cycle on the next cycle. It starts no busy window and leaves the channel's stored code unchanged.
- R7: Writes to a burned channel still change its live code.
- R8: Reset loads a burned channel with its stored code, not 0x80, and the store survives any number of resets.
- R9: The reserved opcode 2'b11, when taken, raises `err` for one cycle and changes no code, store or busy state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; acts as power-up |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken (low while busy) |
| cmd_chan | input | 1 | Channel select |
| cmd_op | input | 2 | 00 write, 01 read, 10 burn, 11 reserved |
| cmd_data | input | 8 | Write code |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | 8 | Read response code |
| busy | output | 1 | Burn window in progress |
| err | output | 1 | One-cycle error pulse |
| fused | output | 2 | Per-channel burned flag |
| wipers | output | 16 | Live codes, channel 0 in the low byte |

## Verification
The bench builds the block with PROG_CYCLES set to 20 instead of a value that spans hundreds of milliseconds. This puts the whole busy window, and the first command taken after it ends, inside a short run. The fuse store is never reset, so one run covers the unburned reset load, burns of both channels, a refused second burn and repeated resets that must keep returning the burned codes.

// File: rtl/wiper_otp_pkg.sv
// Package: shared constants and the command opcode type for the wiper controller.
// Assumes: two-bit opcode field as decoded by the upstream bus parser.
package wiper_otp_pkg;
    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_READ  = 2'b01,
        OP_BURN  = 2'b10,
        OP_RSVD  = 2'b11
    } op_e;
endpackage

// File: rtl/otp_fuse_cell.sv
// Module: one channel's write-once store, modelled as sticky flip-flops.
// Assumes: the store powers up unburned (declaration value) and is never
// cleared by the functional reset; only the first burn request takes effect.
module otp_fuse_cell #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burn,
    input  logic [CODE_W-1:0] burn_code,
    output logic              blown,
    output logic [CODE_W-1:0] stored
);
    logic              blown_q  = 1'b0;
    logic [CODE_W-1:0] stored_q = '0;

    // Capture the code once; later requests leave the cell untouched.
    always_ff @(posedge clk) begin
        if (burn && !blown_q) begin
            blown_q  <= 1'b1;
            stored_q <= burn_code;
        end
    end

    assign blown  = blown_q;
    assign stored = stored_q;

    // R6, R8: a burned cell never changes again
    a_r6_store_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        blown_q |=> (blown_q && $stable(stored_q)));
endmodule

// File: rtl/burn_timer.sv
// Module: counts the busy window that follows a burn.
// Assumes: start is only raised while the window is idle.
module burn_timer #(
    parameter int PROG_CYCLES = 40_000_000,
    localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PROG_CYCLES);
    logic [CNT_W-1:0] remain;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)        remain <= '0;
        else if (start)    remain <= LOAD;
        else if (remain != '0) remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

    // R4: a start opens the busy window on the next cycle
    a_r4_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    // R5: no new start is issued while the window is open
    a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
endmodule

// File: rtl/wiper_channel.sv
// Module: one channel's live wiper code.
// Assumes: reset acts as power-up and reloads from the channel's store.
module wiper_channel #(
    parameter int CODE_W = 8,
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              blown,
    input  logic [CODE_W-1:0] stored,
    output logic [CODE_W-1:0] code
);
    // Reset loads the store or midscale; writes override at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)     code <= blown ? stored : MID;
        else if (wr_en) code <= wr_code;
    end

    // R2, R7: a write lands on the next cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (code == $past(wr_code)));
    // R1, R8: leaving reset shows the power-up code
    a_r8_reset_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (code == (blown ? stored : MID)));
endmodule

// File: rtl/wiper_otp_ctrl.sv
// Module: top of the fuse-backed dual wiper controller.
// Takes one parsed command per handshake, keeps N_CH live codes and
// per-channel write-once stores, and times the burn busy window.
// Assumes: upstream holds cmd_* stable while cmd_valid is high and not taken.
module wiper_otp_ctrl
    import wiper_otp_pkg::*;
#(
    parameter int N_CH        = 2,
    parameter int CODE_W      = 8,
    parameter int PROG_CYCLES = 40_000_000,
    localparam int SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    output logic                     cmd_ready,
    input  logic [SEL_W-1:0]         cmd_chan,
    input  logic [1:0]               cmd_op,
    input  logic [CODE_W-1:0]        cmd_data,
    output logic                     rsp_valid,
    output logic [CODE_W-1:0]        rsp_data,
    output logic                     busy,
    output logic                     err,
    output logic [N_CH-1:0]          fused,
    output logic [N_CH*CODE_W-1:0]   wipers
);
    op_e                 op;
    logic                take;
    logic                sel_blown;
    logic [CODE_W-1:0]   sel_code;
    logic                burn_start;
    logic                err_next;
    logic [CODE_W-1:0]   codes  [N_CH];
    logic [CODE_W-1:0]   stores [N_CH];

    // Decode the handshake and the selected channel's state.
    always_comb begin
        op        = op_e'(cmd_op);
        take      = cmd_valid && !busy;
        sel_blown = fused[cmd_chan];
        sel_code  = codes[cmd_chan];
        burn_start = take && (op == OP_BURN) && !sel_blown;
        err_next   = take && (((op == OP_BURN) && sel_blown) || (op == OP_RSVD));
    end

    assign cmd_ready = !busy;

    genvar c;
    generate
        for (c = 0; c < N_CH; c++) begin : g_ch
            logic hit;
            assign hit = take && (cmd_chan == SEL_W'(c));

            otp_fuse_cell #(.CODE_W(CODE_W)) u_fuse (
                .clk       (clk),
                .rst_n     (rst_n),
                .burn      (hit && (op == OP_BURN)),
                .burn_code (codes[c]),
                .blown     (fused[c]),
                .stored    (stores[c])
            );

            wiper_channel #(.CODE_W(CODE_W)) u_wiper (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (hit && (op == OP_WRITE)),
                .wr_code (cmd_data),
                .blown   (fused[c]),
                .stored  (stores[c]),
                .code    (codes[c])
            );

            assign wipers[c*CODE_W +: CODE_W] = codes[c];
        end
    endgenerate

    burn_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (burn_start),
        .busy  (busy)
    );

    // Register the read response and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            err       <= 1'b0;
        end else begin
            rsp_valid <= take && (op == OP_READ);
            if (take && (op == OP_READ)) rsp_data <= sel_code;
            err       <= err_next;
        end
    end

    // R6, R9: an error never coincides with a fresh busy window
    a_r6_err_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);
    // R3: a response strobe lasts a single cycle unless a new read was taken
    a_r3_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !(take && (op == OP_READ))) |=> !rsp_valid);
    // R4: ready is low throughout the busy window
    a_r4_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cmd_ready);
endmodule

// File: tb/tb_wiper_otp_ctrl.sv
// Bench: behavioural reference model compared with the outputs every cycle.
module tb_wiper_otp_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PROG = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [0:0]  cmd_chan = '0;
    logic [1:0]  cmd_op = '0;
    logic [7:0]  cmd_data = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic        busy;
    logic        err;
    logic [1:0]  fused;
    logic [15:0] wipers;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit cmp_on = 0;

    // reference model state
    int m_w[2];
    int m_fused[2];
    int m_fv[2];
    int m_busy = 0;
    int m_rv = 0;
    int m_rd = 0;
    int m_err = 0;

    wiper_otp_ctrl #(.PROG_CYCLES(PROG)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", what, act, exp, cyc);
        end
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin m_w[i] = 0; m_fused[i] = 0; m_fv[i] = 0; end
    end

    // Model: next state from inputs sampled at the rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) m_w[i] = m_fused[i] ? m_fv[i] : 'h80;
            m_busy = 0; m_rv = 0; m_rd = 0; m_err = 0;
        end else begin
            bit acc;
            int ch;
            acc = cmd_valid && (m_busy == 0);
            ch = int'(cmd_chan);
            m_rv = 0; m_err = 0;
            if (m_busy > 0) m_busy--;
            if (acc) begin
                case (cmd_op)
                    2'b00: m_w[ch] = int'(cmd_data);
                    2'b01: begin m_rv = 1; m_rd = m_w[ch]; end
                    2'b10: if (m_fused[ch] != 0) m_err = 1;
                           else begin m_fused[ch] = 1; m_fv[ch] = m_w[ch]; m_busy = PROG; end
                    default: m_err = 1;
                endcase
            end
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (cmp_on) begin
            chk(int'(wipers[7:0]) == m_w[0], "R2 R7 R8 wiper ch0", wipers[7:0], m_w[0]);
            chk(int'(wipers[15:8]) == m_w[1], "R2 R7 R8 wiper ch1", wipers[15:8], m_w[1]);
            chk(int'(fused) == (m_fused[1]*2 + m_fused[0]), "R4 R6 fused", fused, m_fused[1]*2 + m_fused[0]);
            chk(int'(busy) == int'(m_busy > 0), "R4 R5 busy", busy, m_busy > 0);
            chk(int'(cmd_ready) == int'(m_busy == 0), "R4 R5 cmd_ready", cmd_ready, m_busy == 0);
            chk(int'(err) == m_err, "R6 R9 err", err, m_err);
            chk(int'(rsp_valid) == m_rv, "R3 rsp_valid", rsp_valid, m_rv);
            if (m_rv != 0) chk(int'(rsp_data) == m_rd, "R3 rsp_data", rsp_data, m_rd);
        end
        if (cyc > 5000) begin
            chk(1'b0, "watchdog", cyc, 5000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input bit ch, input logic [1:0] op, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_chan = ch; cmd_op = op; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    initial begin
        idle(3);
        cmp_on = 1;
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        chk(wipers == 16'h8080, "R1 reset codes", wipers, 16'h8080);
        chk(fused == 2'b00 && !busy && !err && !rsp_valid, "R1 reset flags", fused, 0);
        // R2 / R3: writes, boundaries, reads
        send(0, 2'b00, 8'h11);
        send(1, 2'b00, 8'hEE);
        send(0, 2'b01, 8'h00);
        send(1, 2'b01, 8'h00);
        send(0, 2'b00, 8'h00);
        send(1, 2'b00, 8'hFF);
        send(0, 2'b01, 8'h00);
        send(1, 2'b01, 8'h00);
        // R9: reserved opcode
        send(1, 2'b11, 8'h42);
        idle(1);
        chk(wipers == 16'hFF00, "R9 reserved no effect", wipers, 16'hFF00);
        // R4: burn ch0 at 0x5A
        send(0, 2'b00, 8'h5A);
        send(0, 2'b10, 8'h00);
        // R5: commands held during busy are refused
        cmd_valid = 1'b1; cmd_chan = 1'b0; cmd_op = 2'b00; cmd_data = 8'h01;
        idle(5);
        chk(wipers[7:0] == 8'h5A, "R5 write refused while busy", wipers[7:0], 8'h5A);
        cmd_valid = 1'b0;
        idle(PROG);
        // R6: second burn refused
        send(0, 2'b10, 8'h00);
        // R7: temporary override
        send(0, 2'b00, 8'h33);
        send(0, 2'b01, 8'h00);
        idle(1);
        chk(wipers[7:0] == 8'h33, "R7 override after burn", wipers[7:0], 8'h33);
        // R8: reset restores burned code, midscale for the other
        do_reset();
        idle(1);
        chk(wipers == 16'h805A, "R8 reload after reset", wipers, 16'h805A);
        // burn ch1 at 0xFF, then reset twice
        send(1, 2'b00, 8'hFF);
        send(1, 2'b10, 8'h00);
        // a command offered right as busy falls
        cmd_valid = 1'b1; cmd_chan = 1'b1; cmd_op = 2'b01;
        idle(PROG + 2);
        cmd_valid = 1'b0;
        send(1, 2'b10, 8'h00);
        send(1, 2'b00, 8'h07);
        do_reset();
        do_reset();
        idle(1);
        chk(wipers == 16'hFF5A, "R8 both stores survive resets", wipers, 16'hFF5A);
        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule